// File: doc/BRIEF.md
# Waveform Recorder Configuration Register Bank

This block holds every setting of a multi-channel waveform recorder and makes those settings available both to a control bus and to the capture datapath. The control bus is a plain valid/write/address/data port with 16-bit data words and 8-bit word addresses. A write lands in the register on the clock edge that samples it. A read returns its data on the output register one cycle later, and that value holds until the next read.

Settings that cover one bit per channel (up to 128 channels) occupy eight consecutive words, lowest word first. The datapath does not read the bus-visible registers directly. It reads a registered shadow set that follows them one cycle behind. Setting the lock bit freezes that shadow set, so software can rewrite a whole group of settings while the datapath still sees the old, consistent values. Clearing the lock releases all the new values at once.

The bank also holds read-only build constants that describe the instantiated recorder. It holds sticky overflow flags that the capture FIFOs set with single-cycle pulses, one flag per channel per FIFO kind. It holds a signed 16-bit threshold for every channel.

Top module: `wrec_cfg_bank`

## Requirements
- R1: Word 0x00 reads 0xE01E and word 0x01 reads 0x7477 (a 32-bit constant, low half first). `rd_data` takes its new value on the clock edge that samples a read and keeps it until the next read.
- R2: The registers at 0x04 (latency), 0x05 (match window), 0x07 (readout window), 0x39 (sparse cell count) and 0x3A (sparse period) are 16-bit read/write registers. The register at 0x08 keeps only bits 2:0: bit 0 turns zero suppression off, bit 1 turns analog suppression on and bit 2 turns digital suppression on. The register at 0x38 keeps only bit 0 (sparse enable), and 0x03 keeps only bit 0 (lock). Upper bits read zero.
- R3: The per-channel vectors are channel enable at 0x10, polarity at 0x18, digital suppression enable at 0x20 and edge select at 0x28. Channel c sits in the word at base + c[6:4], at bit c[3:0]. Each vector reads back and drives its shadow output with bit c equal to channel c.
- R4: Words 0x30 to 0x37 form a 128-bit read-only build vector. It holds the ADC resolution in bits 15:8, the chip count in 23:16, channels per chip in 31:24, the log2 ring depth in 39:32, the log2 event FIFO depth in 47:40 and the sample rate in Hz in 95:64. All other bits are zero, and writes there have no effect.
- R5: Address 0x80 + c holds the signed 16-bit threshold of channel c. It reads back and reaches `sh_thresh[c*16 +: 16]`.
- R6: A pulse on bit c of `ovf_hist_i`, `ovf_main_i` or `ovf_evt_i` sets a sticky flag, readable at 0x40, 0x48 or 0x50 with the word layout of R3. Bus writes do not change these flags.
- R7: Writing 1 to bit 0 of 0x02 raises `soft_reset_o` for one cycle after that edge and clears every overflow flag on the following edge. A clear and a set in the same cycle leave the flag clear. Word 0x02 reads zero.
- R8: While the lock is clear, every shadow output equals its bus-visible register one clock later.
- R9: While the lock is set, the shadow outputs hold their values even though bus writes still land. They reload on the first edge after the lock reads clear.
- R10: The match window output `sh_match_win` carries the sparse cell count when sparse mode is enabled, and the match window register otherwise.
- R11: Reserved addresses (0x06, 0x09 to 0x0F, 0x3B to 0x3F, 0x58 to 0x7F) read zero and ignore writes.
- R12: After reset, all read/write registers, shadow outputs, overflow flags and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, one cycle after the read |
| ovf_hist_i | input | NUM_CH | Overflow pulses, first FIFO kind |
| ovf_main_i | input | NUM_CH | Overflow pulses, second FIFO kind |
| ovf_evt_i | input | NUM_CH | Overflow pulses, event FIFO |
| soft_reset_o | output | 1 | Soft reset pulse |
| sh_latency | output | 16 | Shadow latency |
| sh_match_win | output | 16 | Shadow effective match window |
| sh_readout_win | output | 16 | Shadow readout window |
| sh_mode | output | 3 | Shadow mode bits |
| sh_sparse_en | output | 1 | Shadow sparse enable |
| sh_sparse_period | output | 16 | Shadow sparse period |
| sh_ch_en | output | NUM_CH | Shadow channel enable |
| sh_polarity | output | NUM_CH | Shadow polarity (1 = active low) |
| sh_dzs_en | output | NUM_CH | Shadow digital suppression enable |
| sh_edge | output | NUM_CH | Shadow edge select (1 = falling) |
| sh_thresh | output | NUM_CH*16 | Shadow thresholds, channel c at bits c*16 +: 16 |

## Verification
A write decoded to the wrong word shows up on the very next read of the neighbouring address, and one cycle later as a wrong bit in a shadow output. A lock that does not hold shows as a shadow output that changes in the cycle after a write made while the lock is set. A lock that fails to release shows as a shadow output that is still stale two edges after the lock is cleared. A sticky flag that leaks or fails to clear is visible on the first read after the overflow pulse or after the soft reset.

// File: rtl/wrec_cfg_pkg.sv
package wrec_cfg_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned MAX_CH  = 128;

   localparam logic [7:0] A_ID_LO  = 8'h00;
   localparam logic [7:0] A_ID_HI  = 8'h01;
   localparam logic [7:0] A_CTRL   = 8'h02;
   localparam logic [7:0] A_LOCK   = 8'h03;
   localparam logic [7:0] A_LAT    = 8'h04;
   localparam logic [7:0] A_MWIN   = 8'h05;
   localparam logic [7:0] A_RWIN   = 8'h07;
   localparam logic [7:0] A_MODE   = 8'h08;
   localparam logic [7:0] A_EN     = 8'h10;
   localparam logic [7:0] A_POL    = 8'h18;
   localparam logic [7:0] A_DZS    = 8'h20;
   localparam logic [7:0] A_EDGE   = 8'h28;
   localparam logic [7:0] A_BUILD  = 8'h30;
   localparam logic [7:0] A_SPCTL  = 8'h38;
   localparam logic [7:0] A_SPCELL = 8'h39;
   localparam logic [7:0] A_SPPER  = 8'h3A;
   localparam logic [7:0] A_OVH    = 8'h40;
   localparam logic [7:0] A_OVM    = 8'h48;
   localparam logic [7:0] A_OVE    = 8'h50;

   localparam logic [31:0] ID_CONST = 32'h7477_E01E;

   typedef logic [WORD_W-1:0] word_t;

   // Packs the read-only build description.
   function automatic logic [127:0] pack_build(input logic [7:0] adc_bits,
                                               input logic [7:0] chips,
                                               input logic [7:0] per_chip,
                                               input logic [7:0] ring_lg,
                                               input logic [7:0] efifo_lg,
                                               input logic [31:0] rate_hz);
      logic [127:0] v;
      v = '0;
      v[15:8]  = adc_bits;
      v[23:16] = chips;
      v[31:24] = per_chip;
      v[39:32] = ring_lg;
      v[47:40] = efifo_lg;
      v[95:64] = rate_hz;
      return v;
   endfunction
endpackage

// File: rtl/wrec_vec_bank.sv
// One per-channel bit vector, spread over NUM_CH/16 consecutive words.
module wrec_vec_bank #(
   parameter int unsigned NUM_CH = 128,
   parameter logic [7:0]  BASE   = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        addr,
   input  logic [15:0]       wdata,
   output logic [NUM_CH-1:0] vec_o
);
   localparam int unsigned NW = NUM_CH / 16;

   logic [15:0] word_q [NW];

   for (genvar w = 0; w < NW; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[w] <= '0;
         else if (wr_en && addr == BASE + 8'(w))
            word_q[w] <= wdata;
      end
      assign vec_o[w*16 +: 16] = word_q[w];
   end
endmodule

// File: rtl/wrec_sticky_vec.sv
// Sticky per-channel overflow flags; clear wins over set.
module wrec_sticky_vec #(
   parameter int unsigned NUM_CH = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic [NUM_CH-1:0] set_i,
   output logic [NUM_CH-1:0] vec_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vec_o <= '0;
      else if (clr_i) vec_o <= '0;
      else            vec_o <= vec_o | set_i;
   end

   assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0 && !clr_i) |=> ((vec_o & $past(set_i)) == $past(set_i)));
   assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && !clr_i) |=> $stable(vec_o));
   assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (vec_o == '0));
endmodule

// File: rtl/wrec_thr_file.sv
// Signed per-channel thresholds, one word each, at BASE + channel.
module wrec_thr_file #(
   parameter int unsigned NUM_CH = 128,
   parameter logic [7:0]  BASE   = 8'h80
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [7:0]           addr,
   input  logic [15:0]          wdata,
   output logic [NUM_CH*16-1:0] thr_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic signed [15:0] thr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            thr_q <= '0;
         else if (wr_en && addr == BASE + 8'(c))
            thr_q <= wdata;
      end
      assign thr_o[c*16 +: 16] = thr_q;
   end
endmodule

// File: rtl/wrec_cfg_bank.sv
module wrec_cfg_bank
   import wrec_cfg_pkg::*;
#(
   parameter int unsigned NUM_CH    = 128,
   parameter int unsigned ADC_BITS  = 14,
   parameter int unsigned CHIPS     = 8,
   parameter int unsigned PER_CHIP  = 16,
   parameter int unsigned RING_LG   = 10,
   parameter int unsigned EFIFO_LG  = 9,
   parameter logic [31:0] RATE_HZ   = 32'd62_500_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [7:0]           bus_addr,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          rd_data,
   input  logic [NUM_CH-1:0]    ovf_hist_i,
   input  logic [NUM_CH-1:0]    ovf_main_i,
   input  logic [NUM_CH-1:0]    ovf_evt_i,
   output logic                 soft_reset_o,
   output logic [15:0]          sh_latency,
   output logic [15:0]          sh_match_win,
   output logic [15:0]          sh_readout_win,
   output logic [2:0]           sh_mode,
   output logic                 sh_sparse_en,
   output logic [15:0]          sh_sparse_period,
   output logic [NUM_CH-1:0]    sh_ch_en,
   output logic [NUM_CH-1:0]    sh_polarity,
   output logic [NUM_CH-1:0]    sh_dzs_en,
   output logic [NUM_CH-1:0]    sh_edge,
   output logic [NUM_CH*16-1:0] sh_thresh
);
   localparam logic [127:0] BUILD_VEC = pack_build(8'(ADC_BITS), 8'(CHIPS),
      8'(PER_CHIP), 8'(RING_LG), 8'(EFIFO_LG), RATE_HZ);

   if (NUM_CH == 0 || NUM_CH > MAX_CH || (NUM_CH % 16) != 0) begin : g_bad_ch
      $error("NUM_CH must be a nonzero multiple of 16 not above 128");
   end
   if (CHIPS * PER_CHIP < NUM_CH) begin : g_bad_chips
      $error("CHIPS * PER_CHIP must cover NUM_CH");
   end
   if (ADC_BITS > 255 || RING_LG > 255 || EFIFO_LG > 255) begin : g_bad_build
      $error("build fields must fit in 8 bits");
   end

   wire wr = bus_valid && bus_write;

   // Scalar registers
   logic        lock_q, sparse_q, soft_q;
   logic [2:0]  mode_q;
   logic [15:0] lat_q, mwin_q, rwin_q, cell_q, per_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;  sparse_q <= 1'b0; soft_q <= 1'b0; mode_q <= '0;
         lat_q  <= '0;    mwin_q   <= '0;   rwin_q <= '0;
         cell_q <= '0;    per_q    <= '0;
      end else begin
         soft_q <= wr && bus_addr == A_CTRL && bus_wdata[0];
         if (wr) begin
            case (bus_addr)
               A_LOCK:   lock_q   <= bus_wdata[0];
               A_LAT:    lat_q    <= bus_wdata;
               A_MWIN:   mwin_q   <= bus_wdata;
               A_RWIN:   rwin_q   <= bus_wdata;
               A_MODE:   mode_q   <= bus_wdata[2:0];
               A_SPCTL:  sparse_q <= bus_wdata[0];
               A_SPCELL: cell_q   <= bus_wdata;
               A_SPPER:  per_q    <= bus_wdata;
               default: ;
            endcase
         end
      end
   end
   assign soft_reset_o = soft_q;

   // Per-channel vectors
   logic [NUM_CH-1:0]    en_v, pol_v, dzs_v, edge_v, ovh_v, ovm_v, ove_v;
   logic [NUM_CH*16-1:0] thr_v;

   wrec_vec_bank #(.NUM_CH(NUM_CH), .BASE(A_EN)) u_en (.clk(clk), .rst_n(rst_n),
      .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata), .vec_o(en_v));
   wrec_vec_bank #(.NUM_CH(NUM_CH), .BASE(A_POL)) u_pol (.clk(clk), .rst_n(rst_n),
      .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata), .vec_o(pol_v));
   wrec_vec_bank #(.NUM_CH(NUM_CH), .BASE(A_DZS)) u_dzs (.clk(clk), .rst_n(rst_n),
      .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata), .vec_o(dzs_v));
   wrec_vec_bank #(.NUM_CH(NUM_CH), .BASE(A_EDGE)) u_edge (.clk(clk), .rst_n(rst_n),
      .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata), .vec_o(edge_v));

   wrec_sticky_vec #(.NUM_CH(NUM_CH)) u_ovh (.clk(clk), .rst_n(rst_n),
      .clr_i(soft_q), .set_i(ovf_hist_i), .vec_o(ovh_v));
   wrec_sticky_vec #(.NUM_CH(NUM_CH)) u_ovm (.clk(clk), .rst_n(rst_n),
      .clr_i(soft_q), .set_i(ovf_main_i), .vec_o(ovm_v));
   wrec_sticky_vec #(.NUM_CH(NUM_CH)) u_ove (.clk(clk), .rst_n(rst_n),
      .clr_i(soft_q), .set_i(ovf_evt_i), .vec_o(ove_v));

   wrec_thr_file #(.NUM_CH(NUM_CH), .BASE(8'h80)) u_thr (.clk(clk), .rst_n(rst_n),
      .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata), .thr_o(thr_v));

   // Read path: vectors padded to full width so absent channels read zero
   logic [127:0]     en_p, pol_p, dzs_p, edge_p, ovh_p, ovm_p, ove_p;
   logic [2047:0]    thr_p;
   logic [6:0]       bit_lo;
   logic [10:0]      thr_lo;
   word_t            rd_word;

   always_comb begin
      en_p = '0;  pol_p = '0; dzs_p = '0; edge_p = '0;
      ovh_p = '0; ovm_p = '0; ove_p = '0; thr_p = '0;
      en_p[NUM_CH-1:0]   = en_v;
      pol_p[NUM_CH-1:0]  = pol_v;
      dzs_p[NUM_CH-1:0]  = dzs_v;
      edge_p[NUM_CH-1:0] = edge_v;
      ovh_p[NUM_CH-1:0]  = ovh_v;
      ovm_p[NUM_CH-1:0]  = ovm_v;
      ove_p[NUM_CH-1:0]  = ove_v;
      thr_p[NUM_CH*16-1:0] = thr_v;
      bit_lo = {bus_addr[2:0], 4'b0000};
      thr_lo = {bus_addr[6:0], 4'b0000};
      rd_word = '0;
      if (bus_addr[7]) begin
         rd_word = thr_p[thr_lo +: 16];
      end else begin
         case (bus_addr[6:3])
            A_EN[6:3]:    rd_word = en_p[bit_lo +: 16];
            A_POL[6:3]:   rd_word = pol_p[bit_lo +: 16];
            A_DZS[6:3]:   rd_word = dzs_p[bit_lo +: 16];
            A_EDGE[6:3]:  rd_word = edge_p[bit_lo +: 16];
            A_BUILD[6:3]: rd_word = BUILD_VEC[bit_lo +: 16];
            A_OVH[6:3]:   rd_word = ovh_p[bit_lo +: 16];
            A_OVM[6:3]:   rd_word = ovm_p[bit_lo +: 16];
            A_OVE[6:3]:   rd_word = ove_p[bit_lo +: 16];
            default: begin
               case (bus_addr)
                  A_ID_LO:  rd_word = ID_CONST[15:0];
                  A_ID_HI:  rd_word = ID_CONST[31:16];
                  A_LOCK:   rd_word = {15'd0, lock_q};
                  A_LAT:    rd_word = lat_q;
                  A_MWIN:   rd_word = mwin_q;
                  A_RWIN:   rd_word = rwin_q;
                  A_MODE:   rd_word = {13'd0, mode_q};
                  A_SPCTL:  rd_word = {15'd0, sparse_q};
                  A_SPCELL: rd_word = cell_q;
                  A_SPPER:  rd_word = per_q;
                  default:  rd_word = '0;
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rd_data <= '0;
      else if (bus_valid && !bus_write) rd_data <= rd_word;
   end

   // Shadow set seen by the datapath
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_latency <= '0; sh_match_win <= '0; sh_readout_win <= '0; sh_mode <= '0;
         sh_sparse_en <= 1'b0; sh_sparse_period <= '0;
         sh_ch_en <= '0; sh_polarity <= '0; sh_dzs_en <= '0; sh_edge <= '0;
         sh_thresh <= '0;
      end else if (!lock_q) begin
         sh_latency       <= lat_q;
         sh_match_win     <= sparse_q ? cell_q : mwin_q;
         sh_readout_win   <= rwin_q;
         sh_mode          <= mode_q;
         sh_sparse_en     <= sparse_q;
         sh_sparse_period <= per_q;
         sh_ch_en         <= en_v;
         sh_polarity      <= pol_v;
         sh_dzs_en        <= dzs_v;
         sh_edge          <= edge_v;
         sh_thresh        <= thr_v;
      end
   end

   assert_shadow_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q |=> (sh_latency == $past(lat_q) && sh_ch_en == $past(en_v)));
   assert_shadow_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(sh_latency) && $stable(sh_thresh) && $stable(sh_ch_en)));
   assert_sparse_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && sparse_q) |=> (sh_match_win == $past(cell_q)));
   assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> $stable(rd_data));
endmodule

// File: tb/tb_wrec_cfg_bank.sv
module tb_wrec_cfg_bank;
   localparam int NUM_CH = 128;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]           bus_addr = '0;
   logic [15:0]          bus_wdata = '0;
   logic [15:0]          rd_data;
   logic [NUM_CH-1:0]    ovf_hist_i = '0, ovf_main_i = '0, ovf_evt_i = '0;
   logic                 soft_reset_o;
   logic [15:0]          sh_latency, sh_match_win, sh_readout_win, sh_sparse_period;
   logic [2:0]           sh_mode;
   logic                 sh_sparse_en;
   logic [NUM_CH-1:0]    sh_ch_en, sh_polarity, sh_dzs_en, sh_edge;
   logic [NUM_CH*16-1:0] sh_thresh;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   wrec_cfg_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
      .ovf_hist_i(ovf_hist_i), .ovf_main_i(ovf_main_i), .ovf_evt_i(ovf_evt_i),
      .soft_reset_o(soft_reset_o), .sh_latency(sh_latency), .sh_match_win(sh_match_win),
      .sh_readout_win(sh_readout_win), .sh_mode(sh_mode), .sh_sparse_en(sh_sparse_en),
      .sh_sparse_period(sh_sparse_period), .sh_ch_en(sh_ch_en), .sh_polarity(sh_polarity),
      .sh_dzs_en(sh_dzs_en), .sh_edge(sh_edge), .sh_thresh(sh_thresh));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = rd_data;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      chk(req, {16'd0, d}, {16'd0, exp});
   endtask

   task automatic t_reset;
      chk("R12 rd_data", {16'd0, rd_data}, 32'd0);
      chk("R12 sh_latency", {16'd0, sh_latency}, 32'd0);
      chk("R12 sh_ch_en", {31'd0, |sh_ch_en}, 32'd0);
      rd_chk("R12 lock", 8'h03, 16'h0000);
      rd_chk("R12 enable word", 8'h10, 16'h0000);
      rd_chk("R12 overflow word", 8'h40, 16'h0000);
   endtask

   task automatic t_id;
      logic [15:0] d;
      rd_chk("R1 id low", 8'h00, 16'hE01E);
      rd_chk("R1 id high", 8'h01, 16'h7477);
      // rd_data must hold after the read while the bus is idle
      rd(8'h01, d);
      @(negedge clk); @(negedge clk);
      chk("R1 hold", {16'd0, rd_data}, 32'h7477);
   endtask

   task automatic t_scalars;
      wr(8'h04, 16'h1234); rd_chk("R2 latency", 8'h04, 16'h1234);
      wr(8'h07, 16'hBEEF); rd_chk("R2 readout", 8'h07, 16'hBEEF);
      wr(8'h3A, 16'h0F0F); rd_chk("R2 period", 8'h3A, 16'h0F0F);
      wr(8'h08, 16'hFFFF); rd_chk("R2 mode mask", 8'h08, 16'h0007);
      @(negedge clk);
      chk("R8 sh_mode", {29'd0, sh_mode}, 32'd7);
      chk("R8 sh_readout", {16'd0, sh_readout_win}, 32'hBEEF);
      wr(8'h08, 16'h0004); @(negedge clk);
      chk("R2 digital suppression bit", {29'd0, sh_mode}, 32'd4);
      wr(8'h38, 16'hFFFE); rd_chk("R2 sparse bit0 only", 8'h38, 16'h0000);
   endtask

   task automatic t_vectors;
      wr(8'h11, 16'h0002);            // channel 17
      wr(8'h1F, 16'h8000);            // polarity channel 127
      wr(8'h20, 16'h0020);            // dzs channel 5
      wr(8'h2D, 16'h0001);            // edge channel 80
      @(negedge clk);
      chk("R3 enable ch17", {31'd0, sh_ch_en[17]}, 32'd1);
      chk("R3 enable only ch17", {24'd0, 8'($countones(sh_ch_en))}, 32'd1);
      chk("R3 polarity ch127", {31'd0, sh_polarity[127]}, 32'd1);
      chk("R3 dzs ch5", {31'd0, sh_dzs_en[5]}, 32'd1);
      chk("R3 edge ch80", {31'd0, sh_edge[80]}, 32'd1);
      rd_chk("R3 readback", 8'h11, 16'h0002);
      rd_chk("R3 neighbour word", 8'h10, 16'h0000);
   endtask

   task automatic t_build;
      rd_chk("R4 resolution", 8'h30, 16'h0E00);
      rd_chk("R4 chips", 8'h31, 16'h1008);
      rd_chk("R4 depths", 8'h32, 16'h090A);
      rd_chk("R4 reserved word", 8'h33, 16'h0000);
      rd_chk("R4 rate low", 8'h34, 16'hACA0);
      rd_chk("R4 rate high", 8'h35, 16'h03B9);
      wr(8'h30, 16'hFFFF);
      rd_chk("R4 write ignored", 8'h30, 16'h0E00);
   endtask

   task automatic t_thresh;
      wr(8'h83, 16'hFF80);
      wr(8'hFF, 16'h7FFF);
      @(negedge clk);
      chk("R5 sh ch3", {16'd0, sh_thresh[3*16 +: 16]}, 32'hFF80);
      chk("R5 sh ch127", {16'd0, sh_thresh[127*16 +: 16]}, 32'h7FFF);
      rd_chk("R5 read ch3", 8'h83, 16'hFF80);
      rd_chk("R5 read ch4", 8'h84, 16'h0000);
   endtask

   task automatic t_overflow;
      @(negedge clk);
      ovf_hist_i[20] = 1'b1; ovf_main_i[0] = 1'b1; ovf_evt_i[127] = 1'b1;
      @(negedge clk);
      ovf_hist_i = '0; ovf_main_i = '0; ovf_evt_i = '0;
      rd_chk("R6 hist ch20", 8'h41, 16'h0010);
      rd_chk("R6 main ch0", 8'h48, 16'h0001);
      rd_chk("R6 evt ch127", 8'h57, 16'h8000);
      wr(8'h41, 16'h0000);
      rd_chk("R6 sticky vs write", 8'h41, 16'h0010);
      wr(8'h02, 16'h0001);
      chk("R7 pulse high", {31'd0, soft_reset_o}, 32'd1);
      @(negedge clk);
      chk("R7 pulse low", {31'd0, soft_reset_o}, 32'd0);
      rd_chk("R7 hist cleared", 8'h41, 16'h0000);
      rd_chk("R7 evt cleared", 8'h57, 16'h0000);
      rd_chk("R7 ctrl reads zero", 8'h02, 16'h0000);
   endtask

   task automatic t_lock;
      wr(8'h04, 16'h0AAA); @(negedge clk);
      chk("R8 follow", {16'd0, sh_latency}, 32'h0AAA);
      wr(8'h03, 16'h0001);
      wr(8'h04, 16'h0BBB);
      wr(8'h12, 16'h0100);
      @(negedge clk); @(negedge clk);
      chk("R9 latency frozen", {16'd0, sh_latency}, 32'h0AAA);
      chk("R9 enable frozen", {31'd0, sh_ch_en[40]}, 32'd0);
      rd_chk("R9 write landed", 8'h04, 16'h0BBB);
      rd_chk("R2 lock reads", 8'h03, 16'h0001);
      wr(8'h03, 16'h0000);
      chk("R9 still frozen at release", {16'd0, sh_latency}, 32'h0AAA);
      @(negedge clk);
      chk("R9 reload", {16'd0, sh_latency}, 32'h0BBB);
      chk("R9 reload enable", {31'd0, sh_ch_en[40]}, 32'd1);
   endtask

   task automatic t_sparse;
      wr(8'h05, 16'h0040);
      wr(8'h39, 16'h0099);
      @(negedge clk);
      chk("R10 window when off", {16'd0, sh_match_win}, 32'h0040);
      wr(8'h38, 16'h0001); @(negedge clk);
      chk("R10 cell count when on", {16'd0, sh_match_win}, 32'h0099);
      chk("R10 sparse flag", {31'd0, sh_sparse_en}, 32'd1);
   endtask

   task automatic t_reserved;
      wr(8'h06, 16'hFFFF);
      wr(8'h3B, 16'hFFFF);
      wr(8'h60, 16'hFFFF);
      rd_chk("R11 0x06", 8'h06, 16'h0000);
      rd_chk("R11 0x3B", 8'h3B, 16'h0000);
      rd_chk("R11 0x60", 8'h60, 16'h0000);
      rd_chk("R11 neighbour 0x05", 8'h05, 16'h0040);
      rd_chk("R11 neighbour 0x07", 8'h07, 16'hBEEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_id();
      t_scalars();
      t_vectors();
      t_build();
      t_thresh();
      t_overflow();
      t_lock();
      t_sparse();
      t_reserved();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule